// File: doc/BRIEF.md
# Serial Peripheral Master with Frame FIFOs

This block is a memory-mapped serial peripheral (SPI) master. Software writes frames into an eight-entry transmit queue through a small register port. The block shifts each frame out most significant bit first on `sclk`/`mosi`. At the same time it captures a frame of the same size from `miso` and places it in an eight-entry receive queue, where software reads it back. Frame size runs from 4 to 16 bits. All four combinations of clock idle level and sampling edge are supported. The bit clock comes from a prescaler and a rate divisor applied to the system clock.

Each transmitted frame produces exactly one received frame. Software can therefore keep the transmit queue filled by counting frames. Three interrupt lines report on the queues. One fires when the receive queue holds at least half its depth. One fires when the transmit queue holds half its depth or less. The third fires when a received frame is lost because the receive queue was full. A loopback setting routes the serial output back to the serial input. An enable bit starts and stops the shift engine without disturbing the queues. Chip selects are driven outside the block.

Top module: `spim_top`

## Requirements
- R1: After reset, every control register reads 0 and `sclk` and all interrupt lines are low. The status register (byte offset 0x0C) reads 0x03: bit 0 is transmit queue empty, bit 1 is transmit queue not full, bit 2 is receive queue not empty, bit 3 is receive queue full and bit 4 is busy.
- R2: Control word 0 (offset 0x00) bits 3:0 give the frame length minus one. Values below 3 select 4 bits. Only the low frame-length bits of a word written to the data register (offset 0x08) are sent. A received frame reads back right-aligned with the upper bits zero.
- R3: Control word 0 bit 6 selects the sampling edge: 0 samples on the leading edge, 1 on the trailing edge. Bit 7 sets the idle level of `sclk`. Bits leave most significant first. After each frame `sclk` rests at the idle level.
- R4: One half-period of `sclk` lasts (P/2)*(S+1) system clocks. S is control word 0 bits 15:8. P is the prescale register (offset 0x10); its bit 0 is ignored and values below 2 act as 2.
- R5: With loopback (control word 1, offset 0x04, bit 3) set, the received frame equals the sent frame, and the level on `miso` has no effect.
- R6: Each queue holds 8 frames. Each frame taken from the transmit queue places one frame into the receive queue. When the engine is idle with both queues drained, status reads 0x03.
- R7: A frame completed while the receive queue is full is discarded, and interrupt status (offset 0x14) bit 2 is set. That bit stays set until any write to offset 0x14.
- R8: Interrupt status bit 0 (receive: queue holds 4 or more) and bit 1 (transmit: queue holds 4 or fewer) follow queue levels. Control word 1 bits 0, 1 and 2 gate bits 0, 1 and 2. The outputs `irq_rx`, `irq_tx` and `irq_ovr` equal those gated bits.
- R9: While control word 1 bit 4 (enable) is clear, no frame is shifted, busy reads 0 and queued frames are kept.
- R10: A data write when the transmit queue is full is dropped. A data read when the receive queue is empty returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| irq_rx | output | 1 | Gated receive-level interrupt |
| irq_tx | output | 1 | Gated transmit-level interrupt |
| irq_ovr | output | 1 | Gated receive-overrun interrupt |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: an eight-deep queue, a five-bit register offset and 32-bit data. With these values both queues can be filled to the brim and one frame more can be pushed, which reaches the overrun and dropped-write paths. It also puts the half-depth interrupt thresholds at four and five entries, where they are checked. A prescale of 2 with a zero divisor gives one-clock half-periods, so every frame length and clock mode runs in loopback within a short run. One external-input frame with a prescale of 5 and a divisor of 2 shows the bit-0 masking of the prescaler and the measured `sclk` period.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int FRAME_MAX = 16;
   localparam int DSS_W     = 4;

   localparam int OFS_CTRL0 = 'h00;
   localparam int OFS_CTRL1 = 'h04;
   localparam int OFS_DATA  = 'h08;
   localparam int OFS_STAT  = 'h0C;
   localparam int OFS_PRE   = 'h10;
   localparam int OFS_IRQ   = 'h14;

   typedef struct packed {
      logic out_off;
      logic slave_sel;
      logic run_en;
      logic loop_en;
      logic ovr_ie;
      logic tx_ie;
      logic rx_ie;
   } ctl1_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
         $error("spim_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rp_q];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         count <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + AW'(1);
         if (do_pop)  rp_q <= rp_q + AW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/spim_shift.sv
module spim_shift
   import spim_pkg::*;
#(
   parameter int CNT_W = 16,
   localparam int EW = DSS_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 cpol,
   input  logic                 cpha,
   input  logic                 lbk,
   input  logic [DSS_W-1:0]     dss,
   input  logic [7:0]           cpsr,
   input  logic [7:0]           scr,
   input  logic                 tx_valid,
   input  logic [FRAME_MAX-1:0] tx_word,
   input  logic                 miso,
   output logic                 tx_pop,
   output logic                 rx_push,
   output logic [FRAME_MAX-1:0] rx_word,
   output logic                 sclk,
   output logic                 mosi,
   output logic                 active
);
   generate
      if (CNT_W < 16) begin : g_cnt_bad
         $error("spim_shift: CNT_W must cover prescale times divisor");
      end
   endgenerate

   logic                 run_q, sclk_q, mosi_q;
   logic [EW-1:0]        edge_q;
   logic [CNT_W-1:0]     cnt_q, half_m1;
   logic [FRAME_MAX-1:0] sh_q, rx_q, rx_nxt, mask;
   logic [FRAME_MAX:0]   mask_w;
   logic [DSS_W-1:0]     top_idx;
   logic [6:0]           pre;
   logic                 tick, lead, sample_ev, shift_ev, last, start, sin;
   logic                 unused_pre;

   assign unused_pre = cpsr[0];
   assign top_idx    = (dss < DSS_W'(3)) ? DSS_W'(3) : dss;
   assign pre        = (cpsr[7:1] == 7'd0) ? 7'd1 : cpsr[7:1];
   assign half_m1    = CNT_W'(16'(pre) * (16'(scr) + 16'd1) - 16'd1);
   assign mask_w     = (FRAME_MAX+1)'(1) << ({1'b0, top_idx} + EW'(1));
   assign mask       = FRAME_MAX'(mask_w - (FRAME_MAX+1)'(1));

   assign tick      = run_q & en & (cnt_q == '0);
   assign lead      = ~edge_q[0];
   assign sample_ev = tick & (lead ^ cpha);
   assign shift_ev  = tick & ~(lead ^ cpha);
   assign last      = tick & (edge_q == {top_idx, 1'b1});
   assign start     = ~run_q & en & tx_valid;
   assign sin       = lbk ? mosi_q : miso;
   assign rx_nxt    = {rx_q[FRAME_MAX-2:0], sin};

   assign tx_pop  = start;
   assign rx_push = last;
   assign rx_word = (sample_ev ? rx_nxt : rx_q) & mask;
   assign sclk    = sclk_q;
   assign mosi    = mosi_q;
   assign active  = run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sclk_q <= 1'b0;
         mosi_q <= 1'b0;
         edge_q <= '0;
         cnt_q  <= '0;
         sh_q   <= '0;
         rx_q   <= '0;
      end else if (start) begin
         run_q  <= 1'b1;
         sclk_q <= cpol;
         edge_q <= '0;
         cnt_q  <= half_m1;
         mosi_q <= tx_word[top_idx];
         sh_q   <= cpha ? tx_word : (tx_word << 1);
         rx_q   <= '0;
      end else if (tick) begin
         cnt_q  <= half_m1;
         sclk_q <= ~sclk_q;
         edge_q <= edge_q + EW'(1);
         if (last) run_q <= 1'b0;
         if (shift_ev) begin
            mosi_q <= sh_q[top_idx];
            sh_q   <= sh_q << 1;
         end
         if (sample_ev) rx_q <= rx_nxt;
      end else if (run_q) begin
         if (en) cnt_q <= cnt_q - CNT_W'(1);
      end else begin
         sclk_q <= cpol;
      end
   end

   p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (last && $stable(cpol)) |=> (sclk_q == cpol));
   p_edge_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && en && cnt_q != '0) |=> $stable(sclk_q));
   p_frozen_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !en) |=> ($stable(sclk_q) && $stable(edge_q)));
endmodule

// File: rtl/spim_top.sv
module spim_top
   import spim_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 8,
   localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              irq_ovr,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   generate
      if (ADDR_W < 5 || DATA_W < FRAME_MAX) begin : g_bus_bad
         $error("spim_top: bus too narrow for the register map");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(OFS_CTRL0);
   localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(OFS_CTRL1);
   localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'(OFS_PRE);
   localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(OFS_IRQ);

   logic [15:0]          ctl0_q;
   ctl1_t                ctl1_q;
   logic [7:0]           pre_q;
   logic                 ovr_q;
   logic                 wr_s, rd_s, tx_push, rx_pop, irq_clr;
   logic [FRAME_MAX-1:0] tx_head, rx_head, rx_in;
   logic [CW-1:0]        tx_cnt, rx_cnt;
   logic                 tx_full, tx_empty, rx_full, rx_empty;
   logic                 sh_pop, sh_push, sh_active, busy;
   logic [2:0]           irq_vec;
   logic [4:0]           stat;
   logic                 unused_bits;

   assign wr_s    = reg_sel & reg_wr;
   assign rd_s    = reg_sel & ~reg_wr;
   assign tx_push = wr_s & (reg_addr == A_DATA);
   assign rx_pop  = rd_s & (reg_addr == A_DATA);
   assign irq_clr = wr_s & (reg_addr == A_IRQ);
   assign unused_bits = ^{reg_wdata[DATA_W-1:16], ctl1_q.out_off, ctl1_q.slave_sel};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl0_q <= '0;
         ctl1_q <= '0;
         pre_q  <= '0;
         ovr_q  <= 1'b0;
      end else begin
         if (wr_s && reg_addr == A_CTRL0) ctl0_q <= reg_wdata[15:0];
         if (wr_s && reg_addr == A_CTRL1) ctl1_q <= ctl1_t'(reg_wdata[6:0]);
         if (wr_s && reg_addr == A_PRE)   pre_q  <= reg_wdata[7:0];
         if (sh_push && rx_full)          ovr_q  <= 1'b1;
         else if (irq_clr)                ovr_q  <= 1'b0;
      end
   end

   spim_fifo #(.WIDTH(FRAME_MAX), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata[FRAME_MAX-1:0]),
      .pop(sh_pop), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

   spim_fifo #(.WIDTH(FRAME_MAX), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(sh_push), .din(rx_in),
      .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

   spim_shift #(.CNT_W(16)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(ctl1_q.run_en), .cpol(ctl0_q[7]), .cpha(ctl0_q[6]),
      .lbk(ctl1_q.loop_en), .dss(ctl0_q[DSS_W-1:0]), .cpsr(pre_q), .scr(ctl0_q[15:8]),
      .tx_valid(~tx_empty), .tx_word(tx_head), .miso(miso), .tx_pop(sh_pop),
      .rx_push(sh_push), .rx_word(rx_in), .sclk(sclk), .mosi(mosi), .active(sh_active));

   assign busy    = ctl1_q.run_en & (sh_active | ~tx_empty);
   assign stat    = {busy, rx_full, ~rx_empty, ~tx_full, tx_empty};
   assign irq_vec = {ovr_q & ctl1_q.ovr_ie,
                     (tx_cnt <= CW'(FIFO_DEPTH/2)) & ctl1_q.tx_ie,
                     (rx_cnt >= CW'(FIFO_DEPTH/2)) & ctl1_q.rx_ie};
   assign irq_rx  = irq_vec[0];
   assign irq_tx  = irq_vec[1];
   assign irq_ovr = irq_vec[2];

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_CTRL0: reg_rdata = DATA_W'(ctl0_q);
         A_CTRL1: reg_rdata = DATA_W'(ctl1_q);
         A_DATA:  reg_rdata = rx_empty ? '0 : DATA_W'(rx_head);
         A_STAT:  reg_rdata = DATA_W'(stat);
         A_PRE:   reg_rdata = DATA_W'(pre_q);
         A_IRQ:   reg_rdata = DATA_W'(irq_vec);
         default: reg_rdata = '0;
      endcase
   end

   p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !irq_clr) |=> ovr_q);
   p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(rx_full && sh_push));
   p_hold_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl1_q.run_en && !tx_push) |=> (tx_cnt == $past(tx_cnt)));
   p_pair_frames_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_push |-> !sh_pop);
endmodule

// File: tb/spim_top_tb_top.sv
module spim_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, we = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wd = '0;
   logic [31:0] rdata;
   logic        irq_rx, irq_tx, irq_ovr, sclk, mosi;
   logic        miso = 1'b1;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;

   logic        slv_on = 1'b0;
   logic [7:0]  slv_sh = '0, slv_cap = '0;

   always #5 clk = ~clk;

   spim_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(we), .reg_addr(addr),
      .reg_wdata(wd), .reg_rdata(rdata), .irq_rx(irq_rx), .irq_tx(irq_tx),
      .irq_ovr(irq_ovr), .sclk(sclk), .mosi(mosi), .miso(miso));

   always @(posedge sclk) if (slv_on) slv_cap <= {slv_cap[6:0], mosi};
   always @(negedge sclk) if (slv_on) begin
      miso   <= slv_sh[7];
      slv_sh <= slv_sh << 1;
   end

   // entry: [25] idle level, [24] phase, [19:16] size field, [15:0] word
   localparam logic [31:0] VEC [8] = '{
      32'h0007_00A5, 32'h0103_000B, 32'h020F_BEEF, 32'h030B_0ABC,
      32'h0000_0FF6, 32'h0308_01C3, 32'h010F_8001, 32'h0204_FFFF };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bwr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wd = d;
      @(negedge clk); sel = 1'b0; we = 1'b0;
   endtask

   task automatic brd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk); sel = 1'b0;
   endtask

   task automatic wait_rx();
      logic [31:0] s;
      do brd(5'h0C, s); while (!(s[2] && !s[4]));
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      do brd(5'h0C, s); while (!(s[0] && !s[4]));
   endtask

   initial begin
      logic [31:0] v;
      logic [15:0] expv;
      int          nb;
      realtime     t1, t2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      brd(5'h0C, v); chk("R1 status", v, 32'h03);
      brd(5'h00, v); chk("R1 ctrl0", v, 32'h0);
      brd(5'h04, v); chk("R1 ctrl1", v, 32'h0);
      chk("R1 lines", {28'd0, sclk, irq_rx, irq_tx, irq_ovr}, 32'h0);

      // R2 R3 R5: loopback vectors, miso held high
      miso = 1'b1;
      bwr(5'h10, 32'd2);
      bwr(5'h04, 32'h18);
      for (int i = 0; i < 8; i++) begin
         nb   = (VEC[i][19:16] < 3) ? 4 : VEC[i][19:16] + 1;
         expv = VEC[i][15:0] & 16'((32'd1 << nb) - 1);
         bwr(5'h00, {24'd0, VEC[i][25:24], 2'b00, VEC[i][19:16]});
         bwr(5'h08, {16'hFFFF, VEC[i][15:0]});
         wait_rx();
         chk("R3 idle level", {31'd0, sclk}, {31'd0, VEC[i][25]});
         brd(5'h08, v); chk("R2 R5 loopback frame", v, {16'd0, expv});
         brd(5'h0C, v); chk("R6 drained", v, 32'h03);
      end

      // R3 R4: external input, leading-edge sample, MSB first
      bwr(5'h04, 32'h10);
      bwr(5'h00, 32'h0207);
      bwr(5'h10, 32'd5);
      slv_cap = '0; slv_sh = 8'h3C << 1; miso = 1'b0; slv_on = 1'b1;
      bwr(5'h08, 32'hD2);
      @(posedge sclk); t1 = $realtime;
      @(posedge sclk); t2 = $realtime;
      chk("R4 sclk period ns", 32'(int'(t2 - t1)), 32'd120);
      wait_rx();
      slv_on = 1'b0;
      brd(5'h08, v); chk("R3 captured miso", v, 32'h3C);
      chk("R3 mosi order", {24'd0, slv_cap}, 32'hD2);

      // R8 R9 R10: queue while disabled
      bwr(5'h10, 32'd2);
      bwr(5'h00, 32'h0007);
      bwr(5'h04, 32'h0F);
      for (int i = 0; i < 4; i++) bwr(5'h08, 32'h10 + i);
      chk("R8 tx irq at 4", {30'd0, irq_tx, irq_rx}, 32'h2);
      bwr(5'h08, 32'h14);
      chk("R8 tx irq at 5", {31'd0, irq_tx}, 32'h0);
      for (int i = 5; i < 8; i++) bwr(5'h08, 32'h10 + i);
      brd(5'h0C, v); chk("R9 full, not busy", v, 32'h00);
      bwr(5'h08, 32'h99);
      repeat (50) @(negedge clk);
      brd(5'h0C, v); chk("R9 nothing shifted", v, 32'h00);

      // R6 R7: enable, fill receive queue, then overrun
      bwr(5'h04, 32'h1F);
      wait_idle();
      brd(5'h0C, v); chk("R6 rx full", v, 32'h0F);
      chk("R8 irq lines", {29'd0, irq_ovr, irq_tx, irq_rx}, 32'h3);
      bwr(5'h08, 32'h77);
      wait_idle();
      repeat (4) @(negedge clk);
      brd(5'h14, v); chk("R7 overrun flagged", v, 32'h7);
      chk("R7 irq_ovr", {31'd0, irq_ovr}, 32'h1);
      for (int i = 0; i < 8; i++) begin
         brd(5'h08, v); chk("R7 R10 kept frames", v, 32'h10 + i);
      end
      brd(5'h08, v); chk("R10 empty read", v, 32'h0);
      brd(5'h14, v); chk("R7 sticky", v, 32'h6);
      bwr(5'h14, 32'h0);
      brd(5'h14, v); chk("R7 cleared", v, 32'h2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule